// File: doc/BRIEF.md
# Line-Address Request Tracker with Aliasing

This block stands between a CPU load/store front end and a cache controller. Each incoming memory request is reduced to its cache-line address and sorted into a read class or a write class. It is then either recorded in the matching table and forwarded to the cache, or refused. A request is refused because the tracker already holds its cap of outstanding requests, or because another request to the same line is still in flight in either table. Completion responses name a line and a class. A matching response frees its entry and reports how many cycles the request was outstanding. A response that matches nothing raises an error pulse and changes no state.

Each request carries an operation code and a store-check flag. The tracker uses the code for two things: the class under which the request is tracked, and the request type it sends to the cache. These two are not always the same. Atomic pairs go out as an atomic type. Locked read-modify-write operations go out as stores. A load marked with store-check is tracked as a write and goes out as a store. Four counters record refusals caused by aliasing, split by the class of the new request and by the table that blocked it.

Top module: `line_req_tracker`

## Requirements
- R1: Requests are matched by line address, which is the request address with its low `LINE_OFF` bits (default 6) dropped. Two addresses that differ only in those bits alias.
- R2: When the outstanding count is at or above `MAX_OUT` (default 8), a valid request gets `req_full`=1 and `req_ready`=0. Nothing is recorded and no stall counter moves. This full condition takes precedence over aliasing.
- R3: `req_op` encoding: 0 load, 1 instruction fetch, 2 store, 3 flush, 4 load-linked, 5 store-conditional, 6 locked RMW read, 7 locked RMW write. Only load and instruction fetch without store-check are read-class. `req_store_chk` has an effect only on op 0.
- R4: A write-class request whose line is in the read table is refused with `req_aliased`=1 and increments `cnt_st_on_ld`. If its line is in the write table instead, it is refused and increments `cnt_st_on_st`.
- R5: A read-class request whose line is in the write table is refused and increments `cnt_ld_on_st`. If its line is already in the read table, it is refused and increments `cnt_ld_on_ld`.
- R6: An accepted request (`req_ready`=1) produces a one-cycle `issue_valid` on the next cycle, with its line, its class and `issue_type`. The encodings are 0 load, 1 fetch, 2 store, 3 flush, 4 atomic. Ops 4 and 5 map to 4. Ops 6 and 7, and a load with store-check, map to 2. All other ops keep their own type. `outstanding` rises by one.
- R7: A response that hits its own table frees the entry and lowers `outstanding` by one. On the next cycle it pulses `done_valid`, with `done_latency` equal to the number of cycles from the request cycle to the response cycle.
- R8: A response whose line is absent from the table of its class pulses `rsp_err` on the next cycle and leaves `outstanding` and both tables unchanged.
- R9: A request and a response in the same cycle both take effect. The request is judged against the table contents from before the removal, and `outstanding` changes by the net amount.
- R10: After reset, `outstanding`, all stall counters, `issue_valid`, `done_valid` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_op | input | 3 | Operation code (R3) |
| req_store_chk | input | 1 | Store-check flag, used with loads only |
| req_ready | output | 1 | Request accepted this cycle |
| req_aliased | output | 1 | Request refused: line already in flight |
| req_full | output | 1 | Request refused: outstanding cap reached |
| issue_valid | output | 1 | Request forwarded to the cache |
| issue_line | output | ADDR_W-LINE_OFF | Line address of the forwarded request |
| issue_type | output | 3 | Type sent to the cache (R6) |
| issue_is_write | output | 1 | Forwarded request is write-class |
| rsp_valid | input | 1 | Completion present this cycle |
| rsp_line | input | ADDR_W-LINE_OFF | Line address of the completion |
| rsp_is_write | input | 1 | Completion targets the write table |
| rsp_err | output | 1 | Previous completion matched no entry |
| done_valid | output | 1 | Previous completion freed an entry |
| done_latency | output | TS_W | Cycles that request was outstanding |
| outstanding | output | $clog2(2*ENTRIES+1) | Entries held across both tables |
| cnt_st_on_ld | output | CNT_W | Write-class refusals caused by the read table |
| cnt_st_on_st | output | CNT_W | Write-class refusals caused by the write table |
| cnt_ld_on_st | output | CNT_W | Read-class refusals caused by the write table |
| cnt_ld_on_ld | output | CNT_W | Read-class refusals caused by the read table |

## Verification
A sequence of requests with no responses fills both tables one line at a time. The next request on each line is placed to hit a specific table from a specific class, so every stall counter moves by exactly one. This separates the four alias paths and shows that the read-table check wins for writes. All eight operation codes and the store-check flag are issued on fresh lines to confirm the type sent to the cache. Once the cap is reached, one request goes to a fresh line and one to an already-tracked line, which shows that the full condition precedes the alias check. Responses that miss, that name the wrong table, and that arrive in the same cycle as a request on the same line or on another line separate the error path from removal and confirm that aliasing is judged before the removal takes effect. A spaced request/response pair fixes the latency count.

// File: rtl/lrt_pkg.sv
// Shared encodings for the line request tracker.
// Assumes: op and issue codes are fixed by the interface to the front end
// and to the cache controller.
package lrt_pkg;
    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_IFETCH  = 3'd1,
        OP_STORE   = 3'd2,
        OP_FLUSH   = 3'd3,
        OP_LL      = 3'd4,
        OP_SC      = 3'd5,
        OP_LOCK_RD = 3'd6,
        OP_LOCK_WR = 3'd7
    } cpu_op_e;

    typedef enum logic [2:0] {
        IT_LOAD   = 3'd0,
        IT_IFETCH = 3'd1,
        IT_STORE  = 3'd2,
        IT_FLUSH  = 3'd3,
        IT_ATOMIC = 3'd4
    } issue_type_e;
endpackage

// File: rtl/lrt_classify.sv
// Maps a CPU operation to its tracking class and to the type sent to the cache.
// Assumes: purely combinational; store_chk only qualifies plain loads.
module lrt_classify
    import lrt_pkg::*;
(
    input  logic [2:0] op,
    input  logic       store_chk,
    output logic       is_write,
    output logic [2:0] itype
);
    // decode class and issued type from the op code
    always_comb begin
        is_write = 1'b1;
        itype    = IT_STORE;
        case (cpu_op_e'(op))
            OP_LOAD: begin
                is_write = store_chk;
                itype    = store_chk ? IT_STORE : IT_LOAD;
            end
            OP_IFETCH: begin
                is_write = 1'b0;
                itype    = IT_IFETCH;
            end
            OP_STORE:   itype = IT_STORE;
            OP_FLUSH:   itype = IT_FLUSH;
            OP_LL:      itype = IT_ATOMIC;
            OP_SC:      itype = IT_ATOMIC;
            OP_LOCK_RD: itype = IT_STORE;
            OP_LOCK_WR: itype = IT_STORE;
            default:    itype = IT_STORE;
        endcase
    end
endmodule

// File: rtl/lrt_table.sv
// Fully associative table of outstanding lines with issue timestamps.
// Assumes: the caller inserts only lines that miss (look_hit = 0) and only when
// a slot is free; insertion and removal may share a cycle on different slots.
module lrt_table #(
    parameter int LINE_W  = 26,
    parameter int ENTRIES = 8,
    parameter int TS_W    = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              ins_en,
    input  logic [TS_W-1:0]   ins_stamp,
    input  logic              rm_en,
    input  logic [LINE_W-1:0] rm_line,
    output logic              rm_hit,
    output logic [TS_W-1:0]   rm_stamp,
    output logic [OCC_W-1:0]  occ
);
    logic [ENTRIES-1:0] valid_q;
    logic [LINE_W-1:0]  line_q  [ENTRIES];
    logic [TS_W-1:0]    stamp_q [ENTRIES];
    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] rm_match;
    logic [IDX_W-1:0]   free_idx;
    logic               has_free;

    // per-slot comparators for lookup and removal
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign look_match[g] = valid_q[g] && (line_q[g] == look_line);
        assign rm_match[g]   = valid_q[g] && (line_q[g] == rm_line);
    end

    assign look_hit = |look_match;
    assign rm_hit   = |rm_match;

    // lowest free slot, stamp of the removed entry and occupancy
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        rm_stamp = '0;
        occ      = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (rm_match[i]) rm_stamp = rm_stamp | stamp_q[i];
            occ = occ + OCC_W'(valid_q[i]);
        end
    end

    // slot state: clear on matched removal, fill the free slot on insert
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (rm_en && rm_match[i]) valid_q[i] <= 1'b0;
                if (ins_en && (free_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    line_q[i]  <= look_line;
                    stamp_q[i] <= ins_stamp;
                end
            end
        end
    end

    // R6
    ins_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !look_hit);

    // R6
    ins_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> has_free);

    // R1
    one_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(look_match) <= 1);
endmodule

// File: rtl/line_req_tracker.sv
// Tracks outstanding CPU memory requests by cache line in separate read and
// write tables, refuses full or aliased requests, and retires completions.
// Assumes: MAX_OUT <= ENTRIES so a table never overflows below the cap.
module line_req_tracker #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 6,
    parameter int ENTRIES  = 8,
    parameter int MAX_OUT  = 8,
    parameter int CNT_W    = 16,
    parameter int TS_W     = 16,
    localparam int LINE_W  = ADDR_W - LINE_OFF,
    localparam int OCC_W   = $clog2(2 * ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_op,
    input  logic              req_store_chk,
    output logic              req_ready,
    output logic              req_aliased,
    output logic              req_full,
    output logic              issue_valid,
    output logic [LINE_W-1:0] issue_line,
    output logic [2:0]        issue_type,
    output logic              issue_is_write,
    input  logic              rsp_valid,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic              rsp_is_write,
    output logic              rsp_err,
    output logic              done_valid,
    output logic [TS_W-1:0]   done_latency,
    output logic [OCC_W-1:0]  outstanding,
    output logic [CNT_W-1:0]  cnt_st_on_ld,
    output logic [CNT_W-1:0]  cnt_st_on_st,
    output logic [CNT_W-1:0]  cnt_ld_on_st,
    output logic [CNT_W-1:0]  cnt_ld_on_ld
);
    localparam int TOCC_W = $clog2(ENTRIES + 1);

    logic [LINE_W-1:0] req_line;
    logic              is_write;
    logic [2:0]        itype;
    logic              rd_hit, wr_hit, rd_rm_hit, wr_rm_hit;
    logic [TS_W-1:0]   rd_stamp, wr_stamp;
    logic [TOCC_W-1:0] rd_occ, wr_occ;
    logic [OCC_W-1:0]  count_q;
    logic [TS_W-1:0]   cyc_q;
    logic              at_cap, any_hit, accept, rsp_hit, retire;

    assign req_line = req_addr[ADDR_W-1:LINE_OFF];

    lrt_classify u_cls (
        .op        (req_op),
        .store_chk (req_store_chk),
        .is_write  (is_write),
        .itype     (itype)
    );

    lrt_table #(.LINE_W(LINE_W), .ENTRIES(ENTRIES), .TS_W(TS_W)) u_rd_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (req_line),
        .look_hit  (rd_hit),
        .ins_en    (accept && !is_write),
        .ins_stamp (cyc_q),
        .rm_en     (rsp_valid && !rsp_is_write),
        .rm_line   (rsp_line),
        .rm_hit    (rd_rm_hit),
        .rm_stamp  (rd_stamp),
        .occ       (rd_occ)
    );

    lrt_table #(.LINE_W(LINE_W), .ENTRIES(ENTRIES), .TS_W(TS_W)) u_wr_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (req_line),
        .look_hit  (wr_hit),
        .ins_en    (accept && is_write),
        .ins_stamp (cyc_q),
        .rm_en     (rsp_valid && rsp_is_write),
        .rm_line   (rsp_line),
        .rm_hit    (wr_rm_hit),
        .rm_stamp  (wr_stamp),
        .occ       (wr_occ)
    );

    // admission decision: the cap is checked before aliasing
    always_comb begin
        at_cap      = (count_q >= OCC_W'(MAX_OUT));
        any_hit     = rd_hit || wr_hit;
        req_full    = req_valid && at_cap;
        req_aliased = req_valid && !at_cap && any_hit;
        accept      = req_valid && !at_cap && !any_hit;
        req_ready   = accept;
        rsp_hit     = rsp_is_write ? wr_rm_hit : rd_rm_hit;
        retire      = rsp_valid && rsp_hit;
    end

    // outstanding count, timestamp counter and registered issue/response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q        <= '0;
            cyc_q          <= '0;
            issue_valid    <= 1'b0;
            issue_line     <= '0;
            issue_type     <= '0;
            issue_is_write <= 1'b0;
            rsp_err        <= 1'b0;
            done_valid     <= 1'b0;
            done_latency   <= '0;
        end else begin
            count_q        <= count_q + OCC_W'(accept) - OCC_W'(retire);
            cyc_q          <= cyc_q + 1'b1;
            issue_valid    <= accept;
            issue_line     <= req_line;
            issue_type     <= itype;
            issue_is_write <= is_write;
            rsp_err        <= rsp_valid && !rsp_hit;
            done_valid     <= retire;
            done_latency   <= cyc_q - (rsp_is_write ? wr_stamp : rd_stamp);
        end
    end

    // stall counters, split by request class and blocking table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_st_on_ld <= '0;
            cnt_st_on_st <= '0;
            cnt_ld_on_st <= '0;
            cnt_ld_on_ld <= '0;
        end else if (req_aliased) begin
            if (is_write) begin
                if (rd_hit) cnt_st_on_ld <= cnt_st_on_ld + 1'b1;
                else        cnt_st_on_st <= cnt_st_on_st + 1'b1;
            end else begin
                if (wr_hit) cnt_ld_on_st <= cnt_ld_on_st + 1'b1;
                else        cnt_ld_on_ld <= cnt_ld_on_ld + 1'b1;
            end
        end
    end

    assign outstanding = count_q;

    // R6
    occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q == OCC_W'(rd_occ) + OCC_W'(wr_occ));

    // R2
    cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= OCC_W'(MAX_OUT));

    // R8
    err_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> count_q == $past(count_q) + OCC_W'($past(req_ready)));

    // R7
    retire_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> count_q == $past(count_q) + OCC_W'($past(req_ready)) - OCC_W'(1));

    // R4
    alias_one_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_aliased |=> ((cnt_st_on_ld != $past(cnt_st_on_ld)) + (cnt_st_on_st != $past(cnt_st_on_st))
                       + (cnt_ld_on_st != $past(cnt_ld_on_st)) + (cnt_ld_on_ld != $past(cnt_ld_on_ld))) == 1);
endmodule

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0] req_op = '0;
    logic req_store_chk = 1'b0;
    logic rsp_valid = 1'b0;
    logic [LINE_W-1:0] rsp_line = '0;
    logic rsp_is_write = 1'b0;
    logic req_ready, req_aliased, req_full, issue_valid, issue_is_write;
    logic [LINE_W-1:0] issue_line;
    logic [2:0] issue_type;
    logic rsp_err, done_valid;
    logic [15:0] done_latency;
    logic [4:0] outstanding;
    logic [15:0] c_sl, c_ss, c_ls, c_ll;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic s_rdy, s_ali, s_full;

    always #4 clk = ~clk;

    line_req_tracker u_line_req_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_store_chk(req_store_chk), .req_ready(req_ready),
        .req_aliased(req_aliased), .req_full(req_full), .issue_valid(issue_valid),
        .issue_line(issue_line), .issue_type(issue_type), .issue_is_write(issue_is_write),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_is_write(rsp_is_write),
        .rsp_err(rsp_err), .done_valid(done_valid), .done_latency(done_latency),
        .outstanding(outstanding), .cnt_st_on_ld(c_sl), .cnt_st_on_st(c_ss),
        .cnt_ld_on_st(c_ls), .cnt_ld_on_ld(c_ll)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle, entered and left at a falling edge; comb outputs sampled mid-cycle
    task automatic step(input logic rv, input logic [31:0] a, input logic [2:0] op,
                        input logic sc, input logic pv, input logic [LINE_W-1:0] pl,
                        input logic pw);
        req_valid = rv; req_addr = a; req_op = op; req_store_chk = sc;
        rsp_valid = pv; rsp_line = pl; rsp_is_write = pw;
        #1;
        s_rdy = req_ready; s_ali = req_aliased; s_full = req_full;
        @(negedge clk);
        req_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    // {addr, op, store_chk, ready, aliased, full, issue_type}
    localparam logic [41:0] VEC [14] = '{
        {32'h1000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {32'h1020, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {32'h1004, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {32'h2000, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2},
        {32'h2010, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {32'h2008, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {32'h3000, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1},
        {32'h4000, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2},
        {32'h5000, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4},
        {32'h6000, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2},
        {32'h7000, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3},
        {32'h9000, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4},
        {32'hA000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0},
        {32'h4000, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 outstanding", 32'(outstanding), 0);
        check("R10 issue_valid", 32'(issue_valid), 0);
        check("R10 counters", 32'(c_sl | c_ss | c_ls | c_ll), 0);
        check("R10 rsp_err/done", 32'({rsp_err, done_valid}), 0);

        // R1 R2 R3 R4 R5 R6 vector walk with no responses
        for (int i = 0; i < 14; i++) begin
            logic [41:0] v;
            v = VEC[i];
            step(1'b1, v[41:10], v[9:7], v[6], 1'b0, '0, 1'b0);
            check($sformatf("R4/R5 aliased vec%0d", i), 32'(s_ali), 32'(v[4]));
            check($sformatf("R2 full vec%0d", i), 32'(s_full), 32'(v[3]));
            check($sformatf("R6 ready vec%0d", i), 32'(s_rdy), 32'(v[5]));
            check($sformatf("R6 issue_valid vec%0d", i), 32'(issue_valid), 32'(v[5]));
            if (v[5]) begin
                check($sformatf("R3 issue_type vec%0d", i), 32'(issue_type), 32'(v[2:0]));
                check($sformatf("R1 issue_line vec%0d", i), 32'(issue_line), v[41:16]);
            end
        end
        check("R6 outstanding at cap", 32'(outstanding), 8);
        check("R4 cnt_st_on_ld", 32'(c_sl), 1);
        check("R4 cnt_st_on_st", 32'(c_ss), 1);
        check("R5 cnt_ld_on_st", 32'(c_ls), 1);
        check("R5 cnt_ld_on_ld", 32'(c_ll), 1);

        // R8 miss and wrong-table responses
        step(1'b0, 0, 0, 0, 1'b1, 26'h2C0, 1'b0);
        check("R8 err on miss", 32'(rsp_err), 1);
        check("R8 no done on miss", 32'(done_valid), 0);
        check("R8 count kept", 32'(outstanding), 8);
        step(1'b0, 0, 0, 0, 1'b1, 26'h040, 1'b1);
        check("R8 err wrong table", 32'(rsp_err), 1);
        check("R8 count kept 2", 32'(outstanding), 8);

        // R7 retire read line 0x40
        step(1'b0, 0, 0, 0, 1'b1, 26'h040, 1'b0);
        check("R7 done_valid", 32'(done_valid), 1);
        check("R7 rsp_err low", 32'(rsp_err), 0);
        check("R7 count dec", 32'(outstanding), 7);

        // R9 same line: request sees entry still present
        step(1'b1, 32'h2000, 3'd0, 1'b0, 1'b1, 26'h080, 1'b1);
        check("R9 aliased before removal", 32'(s_ali), 1);
        check("R9 cnt_ld_on_st", 32'(c_ls), 2);
        check("R9 count after", 32'(outstanding), 6);
        // R9 different lines: net change zero
        step(1'b1, 32'h1000, 3'd2, 1'b0, 1'b1, 26'h140, 1'b1);
        check("R9 accept with retire", 32'(s_rdy), 1);
        check("R9 net count", 32'(outstanding), 6);
        check("R9 done", 32'(done_valid), 1);

        // R3 remaining ops
        step(1'b1, 32'hC000, 3'd7, 1'b0, 1'b0, '0, 1'b0);
        check("R3 lock write type", 32'(issue_type), 2);
        check("R3 lock write class", 32'(issue_is_write), 1);
        step(1'b1, 32'hD000, 3'd2, 1'b1, 1'b0, '0, 1'b0);
        check("R3 store_chk ignored on store", 32'(issue_type), 2);
        check("R6 count 8", 32'(outstanding), 8);

        // R10 reset again, then R7 latency
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset clears count", 32'(outstanding), 0);
        check("R10 reset clears counters", 32'(c_sl | c_ss | c_ls | c_ll), 0);
        step(1'b1, 32'h1010, 3'd1, 1'b0, 1'b0, '0, 1'b0);
        check("R3 ifetch read class", 32'(issue_is_write), 0);
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 0, 1'b0, '0, 1'b0);
        step(1'b0, 0, 0, 0, 1'b1, 26'h040, 1'b0);
        check("R7 latency", 32'(done_latency), 5);
        check("R7 empty", 32'(outstanding), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule